// File: doc/BRIEF.md
# MDIO Compliance Test-Mode Sequencer

This block puts an attached Ethernet PHY into one of its transmit compliance test modes without software help. A single start pulse, together with a test selector, launches a fixed, ordered series of management register accesses. The series covers the gigabit test waveforms, the 100BASE-TX transmit test and the 10BASE-T transmit test. The block contains its own Clause 22 MDIO frame generator. MDC is derived from the system clock.

Every series opens with a subsystem reset. Registers above the 5-bit Clause 22 space are reached indirectly: the 16-bit register address goes into a pointer register, then the value goes into a data register. Single-bit and field updates are done as read-modify-write, so the other bits of the register keep their values. The 10BASE-T series issues a self-clearing soft reset and then polls it until it clears, with a bounded number of polls. When the last frame of a series completes, the block pulses done. Link monitoring and result measurement stay with the host.

Top module: `phy_testmode_seq`

## Requirements
- R1: Each MDIO frame is 64 MDC periods long. It carries, MSB first: 32 ones, start 01, op (01 write, 10 read), the 5-bit PHY address, the 5-bit register address, turnaround, then 16 data bits. A write drives turnaround 10 and keeps mdio_oe high for the whole frame. A read releases mdio_oe from the first turnaround bit to the end of the frame. MDC rises every 2*CLK_DIV clock cycles within a frame and is low when idle.
- R2: Every series starts with four writes: pointer register (PTR_REG, default 0x10) = 0xFF0D, data register (DAT_REG, default 0x11) = 0x0001, pointer = 0xFF0C, data = 0x0001.
- R3: test_sel 1 to 4 selects gigabit test mode 1 to 4. The series is: set bit 11 of register 0, put the mode number into bits 15:13 of register 9, then clear bit 11 of register 0.
- R4: The register 9 update writes (read value & 0x1FFF) | (mode << 13), so bits 12:0 keep the value read.
- R5: test_sel 5 selects 100BASE-TX. The series is: write 0x2900 to register 0, clear bit 10 of register 0x12, clear bit 9 of register 0x12, extended write to 0xB413, set bit 13 of register 0x17, then clear bit 11 of register 0.
- R6: The value written to extended register 0xB413 is test_val, sampled when start is accepted.
- R7: test_sel 6 selects 10BASE-T. The series is: set bit 15 of register 0, poll register 0, write 0x0900 to register 0, extended write of 0x0004 to 0xB412, then clear bit 11 of register 0.
- R8: The poll reads register 0 until bit 15 reads 0, for at most POLL_LIMIT reads. If the last allowed read still shows bit 15 set, the series stops, timeout goes high and done pulses. timeout stays high until the next accepted start clears it.
- R9: A single-bit update is a read of the register followed by a write of the value read with only that bit changed.
- R10: A start pulse while busy is high produces no frame and no extra done.
- R11: A start with test_sel 0 or 7 is ignored: busy stays low and no frame is issued.
- R12: busy is high from the cycle after an accepted start. When the last frame ends, done pulses for exactly one cycle, busy drops in that same cycle, and no frame of the series is still pending.
- R13: After reset, mdc, mdio_oe, busy, done and timeout are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request pulse |
| test_sel | input | 3 | 1-4 gigabit mode, 5 100BASE-TX, 6 10BASE-T |
| test_val | input | 16 | Value for the 100BASE-TX test register |
| phy_addr | input | 5 | PHY address placed in every frame |
| mdio_i | input | 1 | MDIO data returned by the PHY |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO data driven by the block |
| mdio_oe | output | 1 | High while the block drives MDIO |
| busy | output | 1 | A series is in progress |
| done | output | 1 | One-cycle pulse at the end of a series |
| timeout | output | 1 | Soft-reset poll ran out of reads |

## Verification
A wrong step counter or a wrong script entry shows on the pins within one frame. The next frame carries the wrong register address, the wrong op or the wrong data, so it is caught no later than about 64 MDC periods after the error. A fault in the read capture or in the merge path does not show on the read frame itself. It appears in the data field of the write frame that follows the read, so the written value departs from the expected one. A fault in the poll counter shows as a wrong number of read frames before the next write, or as a timeout that is missing or that comes too early.

// File: rtl/tmseq_pkg.sv
package tmseq_pkg;
  localparam int STEP_W = 4;

  localparam logic [15:0] XREG_CFG_REFRESH = 16'hFF0D;
  localparam logic [15:0] XREG_SUBSYS_RST  = 16'hFF0C;
  localparam logic [15:0] XREG_FAST_TEST   = 16'hB413;
  localparam logic [15:0] XREG_TEN_TEST    = 16'hB412;

  typedef enum logic [1:0] {K_WR, K_RMW, K_POLL, K_END} kind_e;

  typedef struct packed {
    kind_e       kind;
    logic [4:0]  rg;
    logic [15:0] val;
    logic [15:0] msk;
  } step_t;

  function automatic step_t mk_step(kind_e k, logic [4:0] r, logic [15:0] v, logic [15:0] m);
    step_t s;
    s.kind = k;
    s.rg   = r;
    s.val  = v;
    s.msk  = m;
    return s;
  endfunction
endpackage

// File: rtl/tmseq_mdio_eng.sv
module tmseq_mdio_eng #(
  parameter int CLK_DIV = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        go,
  input  logic        rd,
  input  logic [4:0]  phy,
  input  logic [4:0]  rg,
  input  logic [15:0] wdata,
  input  logic        mdio_i,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdata
);
  localparam int CW         = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int FRAME_BITS = 64;
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;

  logic [CW-1:0] cnt;
  logic [5:0]    bit_cnt;
  logic [62:0]   sh;
  logic          rd_q;
  logic [63:0]   frame;
  logic          tick;

  assign frame = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10,
                  (rd ? 16'h0000 : wdata)};
  assign tick  = (cnt == CW'(CLK_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      bit_cnt <= '0;
      sh      <= '0;
      rd_q    <= 1'b0;
      mdc     <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      rdata   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (go) begin
          busy    <= 1'b1;
          mdc     <= 1'b0;
          cnt     <= '0;
          bit_cnt <= '0;
          rd_q    <= rd;
          sh      <= frame[62:0];
          mdio_o  <= frame[63];
          mdio_oe <= 1'b1;
        end
      end else if (!tick) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        if (!mdc) begin
          mdc <= 1'b1;
          if (rd_q && (bit_cnt >= 6'(DATA_POS)))
            rdata <= {rdata[14:0], mdio_i};
        end else begin
          mdc <= 1'b0;
          if (bit_cnt == 6'(FRAME_BITS - 1)) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 6'd1;
            sh      <= {sh[61:0], 1'b0};
            mdio_o  <= sh[62];
            mdio_oe <= !(rd_q && ((bit_cnt + 6'd1) >= 6'(TA_POS)));
          end
        end
      end
    end
  end

  // R1: the clock rests low between frames
  assert_mdc_idle_low_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);
  // R1: the line is released for the returned data of a read
  assert_read_released_R1: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_q && bit_cnt >= 6'(DATA_POS)) |-> !mdio_oe);
  // R1: nothing is driven while idle
  assert_idle_no_drive_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);
endmodule

// File: rtl/tmseq_script.sv
module tmseq_script
  import tmseq_pkg::*;
#(
  parameter logic [4:0] PTR_REG = 5'h10,
  parameter logic [4:0] DAT_REG = 5'h11
) (
  input  logic [2:0]        sel,
  input  logic [STEP_W-1:0] step,
  input  logic [15:0]       tval,
  output step_t             op
);
  localparam logic [4:0] R_CTRL  = 5'h00;
  localparam logic [4:0] R_GIG   = 5'h09;
  localparam logic [4:0] R_MDIX  = 5'h12;
  localparam logic [4:0] R_LINK  = 5'h17;

  always_comb begin
    op = mk_step(K_END, 5'h00, 16'h0000, 16'h0000);
    if (step < STEP_W'(4)) begin
      case (step[1:0])
        2'd0:    op = mk_step(K_WR, PTR_REG, XREG_CFG_REFRESH, 16'hFFFF);
        2'd1:    op = mk_step(K_WR, DAT_REG, 16'h0001, 16'hFFFF);
        2'd2:    op = mk_step(K_WR, PTR_REG, XREG_SUBSYS_RST, 16'hFFFF);
        default: op = mk_step(K_WR, DAT_REG, 16'h0001, 16'hFFFF);
      endcase
    end else begin
      case (sel)
        3'd1, 3'd2, 3'd3, 3'd4: begin
          case (step)
            STEP_W'(4): op = mk_step(K_RMW, R_CTRL, 16'h0800, 16'h0800);
            STEP_W'(5): op = mk_step(K_RMW, R_GIG, {sel, 13'h0000}, 16'hE000);
            STEP_W'(6): op = mk_step(K_RMW, R_CTRL, 16'h0000, 16'h0800);
            default:    op = mk_step(K_END, 5'h00, 16'h0000, 16'h0000);
          endcase
        end
        3'd5: begin
          case (step)
            STEP_W'(4):  op = mk_step(K_WR, R_CTRL, 16'h2900, 16'hFFFF);
            STEP_W'(5):  op = mk_step(K_RMW, R_MDIX, 16'h0000, 16'h0400);
            STEP_W'(6):  op = mk_step(K_RMW, R_MDIX, 16'h0000, 16'h0200);
            STEP_W'(7):  op = mk_step(K_WR, PTR_REG, XREG_FAST_TEST, 16'hFFFF);
            STEP_W'(8):  op = mk_step(K_WR, DAT_REG, tval, 16'hFFFF);
            STEP_W'(9):  op = mk_step(K_RMW, R_LINK, 16'h2000, 16'h2000);
            STEP_W'(10): op = mk_step(K_RMW, R_CTRL, 16'h0000, 16'h0800);
            default:     op = mk_step(K_END, 5'h00, 16'h0000, 16'h0000);
          endcase
        end
        3'd6: begin
          case (step)
            STEP_W'(4): op = mk_step(K_RMW, R_CTRL, 16'h8000, 16'h8000);
            STEP_W'(5): op = mk_step(K_POLL, R_CTRL, 16'h0000, 16'h8000);
            STEP_W'(6): op = mk_step(K_WR, R_CTRL, 16'h0900, 16'hFFFF);
            STEP_W'(7): op = mk_step(K_WR, PTR_REG, XREG_TEN_TEST, 16'hFFFF);
            STEP_W'(8): op = mk_step(K_WR, DAT_REG, 16'h0004, 16'hFFFF);
            STEP_W'(9): op = mk_step(K_RMW, R_CTRL, 16'h0000, 16'h0800);
            default:    op = mk_step(K_END, 5'h00, 16'h0000, 16'h0000);
          endcase
        end
        default: op = mk_step(K_END, 5'h00, 16'h0000, 16'h0000);
      endcase
    end
  end
endmodule

// File: rtl/phy_testmode_seq.sv
module phy_testmode_seq
  import tmseq_pkg::*;
#(
  parameter int         CLK_DIV    = 10,
  parameter int         POLL_LIMIT = 1000,
  parameter logic [4:0] PTR_REG    = 5'h10,
  parameter logic [4:0] DAT_REG    = 5'h11
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [2:0]  test_sel,
  input  logic [15:0] test_val,
  input  logic [4:0]  phy_addr,
  input  logic        mdio_i,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        busy,
  output logic        done,
  output logic        timeout
);
  localparam int PW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT + 1) : 1;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_RD_WAIT, S_WR_WAIT, S_NEXT} st_e;

  st_e               st;
  logic [2:0]        sel_q;
  logic [15:0]       tval_q;
  logic [STEP_W-1:0] step;
  logic [PW-1:0]     poll_cnt;
  logic              eng_go, eng_rd, eng_busy, eng_done;
  logic [4:0]        eng_reg;
  logic [15:0]       eng_wdata, eng_rdata;
  step_t             op;
  logic              sel_ok;

  assign sel_ok = (test_sel >= 3'd1) && (test_sel <= 3'd6);

  tmseq_script #(.PTR_REG(PTR_REG), .DAT_REG(DAT_REG)) u_script (
    .sel (sel_q),
    .step(step),
    .tval(tval_q),
    .op  (op)
  );

  tmseq_mdio_eng #(.CLK_DIV(CLK_DIV)) u_eng (
    .clk    (clk),
    .rst    (rst),
    .go     (eng_go),
    .rd     (eng_rd),
    .phy    (phy_addr),
    .rg     (eng_reg),
    .wdata  (eng_wdata),
    .mdio_i (mdio_i),
    .mdc    (mdc),
    .mdio_o (mdio_o),
    .mdio_oe(mdio_oe),
    .busy   (eng_busy),
    .done   (eng_done),
    .rdata  (eng_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      sel_q     <= '0;
      tval_q    <= '0;
      step      <= '0;
      poll_cnt  <= '0;
      eng_go    <= 1'b0;
      eng_rd    <= 1'b0;
      eng_reg   <= '0;
      eng_wdata <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      timeout   <= 1'b0;
    end else begin
      eng_go <= 1'b0;
      done   <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start && sel_ok) begin
            sel_q    <= test_sel;
            tval_q   <= test_val;
            step     <= '0;
            poll_cnt <= '0;
            timeout  <= 1'b0;
            busy     <= 1'b1;
            st       <= S_FETCH;
          end
        end
        S_FETCH: begin
          eng_reg <= op.rg;
          case (op.kind)
            K_WR: begin
              eng_go    <= 1'b1;
              eng_rd    <= 1'b0;
              eng_wdata <= op.val;
              st        <= S_WR_WAIT;
            end
            K_RMW, K_POLL: begin
              eng_go <= 1'b1;
              eng_rd <= 1'b1;
              st     <= S_RD_WAIT;
            end
            default: begin
              done <= 1'b1;
              busy <= 1'b0;
              st   <= S_IDLE;
            end
          endcase
        end
        S_RD_WAIT: begin
          if (eng_done) begin
            if (op.kind == K_POLL) begin
              if ((eng_rdata & op.msk) == 16'h0000) begin
                poll_cnt <= '0;
                st       <= S_NEXT;
              end else if (poll_cnt == PW'(POLL_LIMIT - 1)) begin
                timeout <= 1'b1;
                done    <= 1'b1;
                busy    <= 1'b0;
                st      <= S_IDLE;
              end else begin
                poll_cnt <= poll_cnt + 1'b1;
                eng_go   <= 1'b1;
                eng_rd   <= 1'b1;
              end
            end else begin
              eng_go    <= 1'b1;
              eng_rd    <= 1'b0;
              eng_wdata <= (eng_rdata & ~op.msk) | (op.val & op.msk);
              st        <= S_WR_WAIT;
            end
          end
        end
        S_WR_WAIT: begin
          if (eng_done) st <= S_NEXT;
        end
        S_NEXT: begin
          step <= step + 1'b1;
          st   <= S_FETCH;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1: a frame is only launched into an idle engine
  assert_launch_idle_R1: assert property (@(posedge clk) disable iff (rst)
    eng_go |-> !eng_busy);
  // R12: done is a single-cycle pulse and coincides with busy low
  assert_done_single_R12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_not_busy_R12: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R8: timeout rises only as a series ends
  assert_timeout_ends_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout) |-> done);
  // R10: a start during a series leaves the latched selection alone
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(sel_q));
endmodule

// File: tb/phy_testmode_seq_tb.sv
module phy_testmode_seq_tb;
  localparam int CLK_DIV    = 2;
  localparam int POLL_LIMIT = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  test_sel = 3'd0;
  logic [15:0] test_val = 16'h0000;
  logic [4:0]  paddr = 5'h03;
  logic        mdio_i = 1'b1;
  logic        mdc, mdio_o, mdio_oe, busy, done, timeout;

  always #10 clk = ~clk;

  phy_testmode_seq #(.CLK_DIV(CLK_DIV), .POLL_LIMIT(POLL_LIMIT)) u_dut (
    .clk(clk), .rst(rst), .start(start), .test_sel(test_sel), .test_val(test_val),
    .phy_addr(paddr), .mdio_i(mdio_i), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .busy(busy), .done(done), .timeout(timeout)
  );

  typedef struct {
    logic [1:0]  op;
    logic [4:0]  rg;
    logic [15:0] dat;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int failures = 0;
  int done_cnt = 0;
  int cyc = 0;

  logic [15:0] mem [32];
  int rst_cnt = 0;
  bit stuck = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, expv);
    end
  endtask

  task automatic push_wr(input logic [4:0] r, input logic [15:0] d, input string tag);
    exp_t e;
    e.op = 2'b01; e.rg = r; e.dat = d; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic push_rd(input logic [4:0] r, input string tag);
    exp_t e;
    e.op = 2'b10; e.rg = r; e.dat = 16'h0; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic push_reset_seq();
    push_wr(5'h10, 16'hFF0D, "R2");
    push_wr(5'h11, 16'h0001, "R2");
    push_wr(5'h10, 16'hFF0C, "R2");
    push_wr(5'h11, 16'h0001, "R2");
  endtask

  task automatic reset_model(input logic [15:0] r9, input bit s);
    for (int i = 0; i < 32; i++) mem[i] = 16'h0000;
    mem[0]  = 16'h1140;
    mem[9]  = r9;
    mem[18] = 16'h0E02;
    mem[23] = 16'h0005;
    rst_cnt = 0;
    stuck = s;
  endtask

  task automatic mdl_read(input logic [4:0] r, output logic [15:0] v);
    if (r == 5'd0 && mem[0][15] && !stuck) begin
      if (rst_cnt == 0) mem[0][15] = 1'b0;
      else rst_cnt--;
    end
    v = mem[r];
  endtask

  task automatic mdl_write(input logic [4:0] r, input logic [15:0] d);
    mem[r] = d;
    if (r == 5'd0 && d[15]) rst_cnt = 2;
  endtask

  // monitor: decodes frames, plays the PHY, pops the scoreboard
  int n = 0;
  int since = 0;
  logic mdc_q = 1'b0;
  logic done_q = 1'b0;
  logic [63:0] frm = '0;
  bit is_rd = 0;
  bit oe_ok = 1;
  logic [15:0] rdv = '0;

  always @(negedge clk) begin
    if (rst) begin
      n = 0; since = 0; mdc_q = 1'b0; mdio_i = 1'b1; done_q = 1'b0;
    end else begin
      if (mdc && !mdc_q) begin
        n++;
        if (n > 1) chk((since + 1) == 2 * CLK_DIV, "R1", "mdc period", since + 1, 2 * CLK_DIV);
        since = 0;
        frm = {frm[62:0], mdio_o};
        if (n == 1) oe_ok = 1;
        if (n <= 46 || !is_rd) oe_ok = oe_ok && mdio_oe;
        else oe_ok = oe_ok && !mdio_oe;
        if (n == 46) begin
          is_rd = (frm[11:10] == 2'b10);
          if (is_rd) mdl_read(frm[4:0], rdv);
        end
        if (n == 47 && is_rd) mdio_i = 1'b0;
        if (n >= 48 && n <= 63 && is_rd) mdio_i = rdv[63 - n];
        if (n == 64) begin
          mdio_i = 1'b1;
          chk(frm[63:32] == 32'hFFFF_FFFF, "R1", "preamble", frm[63:32], 32'hFFFF_FFFF);
          chk(frm[31:30] == 2'b01, "R1", "start bits", frm[31:30], 2'b01);
          chk(frm[27:23] == paddr, "R1", "phy address", frm[27:23], paddr);
          chk(oe_ok, "R1", "mdio_oe pattern", oe_ok, 1);
          if (exp_q.size() == 0) begin
            chk(0, "R11", "unexpected frame reg", frm[22:18], 0);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(frm[29:28] == e.op, e.tag, "op", frm[29:28], e.op);
            chk(frm[22:18] == e.rg, e.tag, "register", frm[22:18], e.rg);
            if (e.op == 2'b01) begin
              chk(frm[17:16] == 2'b10, "R1", "turnaround", frm[17:16], 2'b10);
              chk(frm[15:0] == e.dat, e.tag, "write data", frm[15:0], e.dat);
            end
          end
          if (!is_rd) mdl_write(frm[22:18], frm[15:0]);
          is_rd = 0;
          n = 0;
        end
      end else begin
        since++;
      end
      mdc_q = mdc;
      if (done) begin
        done_cnt++;
        if (done_q) chk(0, "R12", "done width", 2, 1);
      end
      done_q = done;
    end
  end

  // watchdog
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog R12 actual=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic run(input logic [2:0] sel, input logic [15:0] tv);
    @(negedge clk);
    start = 1'b1; test_sel = sel; test_val = tv;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R12", "busy after start", busy, 1);
    chk(timeout == 1'b0, "R8", "timeout cleared on start", timeout, 0);
  endtask

  task automatic wait_done(input bit exp_to, input string tag);
    do @(negedge clk); while (!done);
    chk(exp_q.size() == 0, "R12", {"frames pending at done ", tag}, exp_q.size(), 0);
    chk(timeout == exp_to, "R8", {"timeout flag ", tag}, timeout, exp_to);
    @(negedge clk);
    chk(!busy && !done, "R12", "busy/done after end", {busy, done}, 0);
    chk(!mdc && !mdio_oe, "R1", "idle lines", {mdc, mdio_oe}, 0);
  endtask

  task automatic push_gig(input logic [2:0] m, input logic [15:0] r9);
    push_reset_seq();
    push_rd(5'h00, "R9");
    push_wr(5'h00, 16'h1940, "R9");
    push_rd(5'h09, "R3");
    push_wr(5'h09, (r9 & 16'h1FFF) | {m, 13'h0}, "R4");
    push_rd(5'h00, "R3");
    push_wr(5'h00, 16'h1140, "R3");
  endtask

  task automatic push_fast(input logic [15:0] tv);
    push_reset_seq();
    push_wr(5'h00, 16'h2900, "R5");
    push_rd(5'h12, "R5");
    push_wr(5'h12, 16'h0A02, "R9");
    push_rd(5'h12, "R5");
    push_wr(5'h12, 16'h0802, "R9");
    push_wr(5'h10, 16'hB413, "R5");
    push_wr(5'h11, tv, "R6");
    push_rd(5'h17, "R5");
    push_wr(5'h17, 16'h2005, "R5");
    push_rd(5'h00, "R5");
    push_wr(5'h00, 16'h2100, "R5");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    chk({mdc, mdio_oe, busy, done, timeout} == 5'b0, "R13", "reset outputs",
        {mdc, mdio_oe, busy, done, timeout}, 0);

    // gigabit mode 1
    reset_model(16'h0200, 0);
    push_gig(3'd1, 16'h0200);
    run(3'd1, 16'h0000);
    wait_done(0, "R3");

    // gigabit mode 4, other bits of register 9 all ones, new address
    paddr = 5'h1A;
    reset_model(16'hFFFF, 0);
    push_gig(3'd4, 16'hFFFF);
    run(3'd4, 16'h0000);
    wait_done(0, "R4");

    // 100BASE-TX
    reset_model(16'h0200, 0);
    push_fast(16'h0003);
    run(3'd5, 16'h0003);
    wait_done(0, "R5");

    // 10BASE-T with soft reset clearing on third poll
    reset_model(16'h0200, 0);
    push_reset_seq();
    push_rd(5'h00, "R7");
    push_wr(5'h00, 16'h9140, "R9");
    push_rd(5'h00, "R8");
    push_rd(5'h00, "R8");
    push_rd(5'h00, "R8");
    push_wr(5'h00, 16'h0900, "R7");
    push_wr(5'h10, 16'hB412, "R7");
    push_wr(5'h11, 16'h0004, "R7");
    push_rd(5'h00, "R7");
    push_wr(5'h00, 16'h0100, "R7");
    run(3'd6, 16'h0000);
    wait_done(0, "R7");

    // 10BASE-T with soft reset stuck: timeout after POLL_LIMIT reads
    paddr = 5'h05;
    reset_model(16'h0200, 1);
    push_reset_seq();
    push_rd(5'h00, "R7");
    push_wr(5'h00, 16'h9140, "R9");
    for (int i = 0; i < POLL_LIMIT; i++) push_rd(5'h00, "R8");
    run(3'd6, 16'h0000);
    wait_done(1, "R8");

    // gigabit mode 2 with a second start while busy (R10)
    reset_model(16'h0200, 0);
    push_gig(3'd2, 16'h0200);
    run(3'd2, 16'h0000);
    repeat (100) @(negedge clk);
    start = 1'b1; test_sel = 3'd5; test_val = 16'hFFFF;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10", "still busy after extra start", busy, 1);
    wait_done(0, "R10");

    // invalid selectors (R11)
    @(negedge clk);
    start = 1'b1; test_sel = 3'd0;
    @(negedge clk);
    test_sel = 3'd7;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R11", "busy after invalid start", busy, 0);
    repeat (600) @(negedge clk);
    chk(n == 0 && !mdc, "R11", "mdc activity after invalid start", n, 0);

    // 100BASE-TX with another test value
    reset_model(16'h0200, 0);
    push_fast(16'hA5C3);
    run(3'd5, 16'hA5C3);
    wait_done(0, "R6");

    repeat (5) @(negedge clk);
    chk(done_cnt == 7, "R12", "done pulse count", done_cnt, 7);
    chk(exp_q.size() == 0, "R12", "scoreboard empty", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule